// File: doc/BRIEF.md
# Unaligned Byte-Lane Memory Access Bridge

This bridge sits between a processor's 32-bit data port and a word-organised 32-bit memory on a Wishbone-style bus. The processor side is byte-addressed. Each request moves 1, 2 or 4 bytes, and its data is always right-justified in the low bits of the data word. The memory side only understands aligned words with per-lane byte enables.

For each request the bridge steers the bytes onto the correct memory lanes. When an access runs past the end of a word, the bridge issues a second aligned cycle to the following word. For loads it gathers the returned bytes back into the low bits. A 1- or 2-byte load can be sign- or zero-extended. The processor sees a single acknowledge per access, whether one or two memory cycles were needed.

Top module: `lane_split_bridge`

## Requirements
- R1: After reset, and until a request is presented, `mem_cyc`, `mem_stb` and `up_ack` are low.
- R2: The width of an access is taken from `up_sel`: 4'b0001 selects 1 byte, 4'b0011 selects 2 bytes and 4'b1111 selects 4 bytes. Byte k of the access occupies bits [8k+7:8k] of the upstream data and belongs to byte address A+k (little-endian).
- R3: The first memory cycle uses word address `up_adr[20:2]`. Its `mem_sel` is the low four bits of the access's lane mask shifted left by `up_adr[1:0]` lanes.
- R4: When offset plus width exceeds 4 bytes, a second memory cycle follows at word address +1. Its `mem_sel` carries the lanes that overflowed, and `mem_cyc` stays high from the first cycle until the access completes.
- R5: An access that fits within one word uses exactly one memory cycle.
- R6: `up_ack` is a single-cycle pulse, raised only after every memory cycle of the access has been acknowledged.
- R7: A store changes only the memory bytes at addresses A to A+width-1. Bytes of `up_wdat` above the access width have no effect on memory.
- R8: A load returns the bytes at A, A+1, ... right-justified in `up_rdat`, including accesses that cross a word boundary. For example, words 0x92837400 at byte 0x00 and 0xBECD0001 at byte 0x04 give 0xCD000192 for a 4-byte load at byte 0x03.
- R9: When `up_sext` is high, a 1-byte load fills bits [31:8] with bit 7 and a 2-byte load fills bits [31:16] with bit 15. When `up_sext` is low, those bits are zero.
- R10: A request is taken only while the bridge is idle. Upstream inputs are captured at acceptance, so changing them while the access is in progress has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_cyc | input | 1 | Upstream bus cycle active |
| up_stb | input | 1 | Upstream request strobe |
| up_we | input | 1 | Upstream write enable (1 = store) |
| up_adr | input | 21 | Upstream byte address |
| up_sel | input | 4 | Upstream low-justified byte select (access width) |
| up_sext | input | 1 | Sign-extend a 1- or 2-byte load |
| up_wdat | input | 32 | Upstream right-justified write data |
| up_rdat | output | 32 | Upstream right-justified load result, valid with `up_ack` |
| up_ack | output | 1 | Upstream access complete |
| mem_cyc | output | 1 | Memory bus cycle active |
| mem_stb | output | 1 | Memory strobe |
| mem_we | output | 1 | Memory write enable |
| mem_adr | output | 19 | Memory word address |
| mem_sel | output | 4 | Memory byte-lane enables |
| mem_wdat | output | 32 | Memory write data, lane-aligned |
| mem_rdat | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory cycle acknowledge |

## Verification
The bench targets the following corner cases:
- **Offset-3 accesses of 2 and 4 bytes, and offset-1 and offset-2 4-byte accesses.** These split into two cycles. A design that drops the second cycle loses the overflow bytes. One that addresses the second cycle wrongly corrupts a neighbouring word.
- **Byte stores with garbage in the upper write bytes.** A design that enables too many lanes overwrites neighbours, which the bench catches when it reads those neighbours back.
- **Sign and zero extension with the top bit both set and clear.** A design that extends from the wrong bit, or extends a full-word load, returns upper bits that do not match.
- **Inputs scrambled while an access is in flight.** A bridge that does not capture its request steers data or lanes from the changed inputs.
- **The word-boundary wrap.** Accesses at the top of the modelled address range check that the second word address is the first plus one.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_REPLY} phase_e;
    typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_FULL} width_e;
endpackage

// File: rtl/byte_steer.sv
module byte_steer #(
    parameter int NB    = 4,
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [NB-1:0]     lanes,
    input  logic [8*NB-1:0]   wdat,
    output logic [NB-1:0]     sel_lo,
    output logic [NB-1:0]     sel_hi,
    output logic [8*NB-1:0]   dat_lo,
    output logic [8*NB-1:0]   dat_hi,
    output logic              split
);
    localparam int DW = 8 * NB;

    logic [DW-1:0]   masked;
    logic [2*NB-1:0] wide_sel;
    logic [2*DW-1:0] wide_dat;

    // drop bytes above the access width before they are steered
    for (genvar k = 0; k < NB; k++) begin : g_mask
        assign masked[8*k +: 8] = lanes[k] ? wdat[8*k +: 8] : 8'h00;
    end

    assign wide_sel = {{NB{1'b0}}, lanes} << ofs;
    assign wide_dat = {{DW{1'b0}}, masked} << {ofs, 3'b000};
    assign sel_lo   = wide_sel[NB-1:0];
    assign sel_hi   = wide_sel[2*NB-1:NB];
    assign dat_lo   = wide_dat[DW-1:0];
    assign dat_hi   = wide_dat[2*DW-1:DW];
    assign split    = |sel_hi;

    // an overflowing access must also occupy the top lane of the first word
    always_comb begin
        if (split) begin
            p_split_top_lane_r4: assert (sel_lo[NB-1]);
        end
    end
endmodule

// File: rtl/lane_gather.sv
module lane_gather
    import lsb_pkg::*;
#(
    parameter int NB    = 4,
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0]  ofs,
    input  width_e            size,
    input  logic              sext,
    input  logic [8*NB-1:0]   lo,
    input  logic [8*NB-1:0]   hi,
    output logic [8*NB-1:0]   rdat
);
    localparam int DW = 8 * NB;

    logic [2*DW-1:0] wide;
    logic [DW-1:0]   low;

    assign wide = {hi, lo} >> {ofs, 3'b000};
    assign low  = wide[DW-1:0];

    always_comb begin
        unique case (size)
            SZ_BYTE: rdat = {{(DW-8){sext & low[7]}}, low[7:0]};
            SZ_HALF: rdat = {{(DW-16){sext & low[15]}}, low[15:0]};
            default: rdat = low;
        endcase
    end
endmodule

// File: rtl/lane_split_bridge.sv
module lane_split_bridge
    import lsb_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         up_cyc,
    input  logic                         up_stb,
    input  logic                         up_we,
    input  logic [ADDR_W-1:0]            up_adr,
    input  logic [DATA_W/8-1:0]          up_sel,
    input  logic                         up_sext,
    input  logic [DATA_W-1:0]            up_wdat,
    output logic [DATA_W-1:0]            up_rdat,
    output logic                         up_ack,
    output logic                         mem_cyc,
    output logic                         mem_stb,
    output logic                         mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_adr,
    output logic [DATA_W/8-1:0]          mem_sel,
    output logic [DATA_W-1:0]            mem_wdat,
    input  logic [DATA_W-1:0]            mem_rdat,
    input  logic                         mem_ack
);
    localparam int NB     = DATA_W / 8;
    localparam int OFS_W  = $clog2(NB);
    localparam int WADR_W = ADDR_W - OFS_W;

    typedef struct packed {
        phase_e              phase;
        logic [WADR_W-1:0]   wadr;
        logic [OFS_W-1:0]    ofs;
        width_e              size;
        logic                we;
        logic                sext;
        logic [DATA_W-1:0]   wdat;
        logic [DATA_W-1:0]   lo;
        logic [DATA_W-1:0]   hi;
    } regs_t;

    regs_t q, d;

    function automatic width_e decode_width(input logic [NB-1:0] sel);
        if (|sel[NB-1:2]) return SZ_FULL;
        if (sel[1])       return SZ_HALF;
        return SZ_BYTE;
    endfunction

    function automatic logic [NB-1:0] lanes_of(input width_e w);
        unique case (w)
            SZ_BYTE: return {{(NB-1){1'b0}}, 1'b1};
            SZ_HALF: return {{(NB-2){1'b0}}, 2'b11};
            default: return {NB{1'b1}};
        endcase
    endfunction

    logic [NB-1:0]     sel_lo_w, sel_hi_w;
    logic [DATA_W-1:0] dat_lo_w, dat_hi_w;
    logic              split_w;
    logic              busy;

    byte_steer #(.NB(NB), .OFS_W(OFS_W)) u_steer (
        .ofs    (q.ofs),
        .lanes  (lanes_of(q.size)),
        .wdat   (q.wdat),
        .sel_lo (sel_lo_w),
        .sel_hi (sel_hi_w),
        .dat_lo (dat_lo_w),
        .dat_hi (dat_hi_w),
        .split  (split_w)
    );

    lane_gather #(.NB(NB), .OFS_W(OFS_W)) u_gather (
        .ofs  (q.ofs),
        .size (q.size),
        .sext (q.sext),
        .lo   (q.lo),
        .hi   (q.hi),
        .rdat (up_rdat)
    );

    always_comb begin
        d = q;
        unique case (q.phase)
            ST_IDLE: begin
                if (up_cyc && up_stb) begin
                    d.phase = ST_LOW;
                    d.wadr  = up_adr[ADDR_W-1:OFS_W];
                    d.ofs   = up_adr[OFS_W-1:0];
                    d.size  = decode_width(up_sel);
                    d.we    = up_we;
                    d.sext  = up_sext;
                    d.wdat  = up_wdat;
                end
            end
            ST_LOW: begin
                if (mem_ack) begin
                    d.lo    = mem_rdat;
                    d.phase = split_w ? ST_HIGH : ST_REPLY;
                end
            end
            ST_HIGH: begin
                if (mem_ack) begin
                    d.hi    = mem_rdat;
                    d.phase = ST_REPLY;
                end
            end
            default: d.phase = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.phase == ST_LOW) || (q.phase == ST_HIGH);
    assign mem_cyc  = busy;
    assign mem_stb  = busy;
    assign mem_we   = busy && q.we;
    assign mem_adr  = (q.phase == ST_HIGH) ? q.wadr + {{(WADR_W-1){1'b0}}, 1'b1} : q.wadr;
    assign mem_sel  = !busy ? '0 : ((q.phase == ST_HIGH) ? sel_hi_w : sel_lo_w);
    assign mem_wdat = (q.phase == ST_HIGH) ? dat_hi_w : dat_lo_w;
    assign up_ack   = (q.phase == ST_REPLY);

    // R1: bus quiet when reset is released
    p_quiet_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!mem_stb && !mem_cyc && !up_ack));

    // R3: a strobed cycle always enables at least one lane
    p_lanes_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> (mem_sel != '0));

    // R4: the cycle that follows an acknowledged one targets the next word
    p_next_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && $past(mem_stb && mem_ack)) |-> (mem_adr == $past(mem_adr) + 1'b1));

    // R4: the memory cycle only ends together with the upstream reply
    p_cyc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cyc) |-> up_ack);

    // R6: the upstream acknowledge lasts one cycle
    p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_ack |=> !up_ack);

    // R9: an unextended byte load carries zeros above bit 7
    p_zero_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_ack && !q.we && q.size == SZ_BYTE && !q.sext) |-> (up_rdat[DATA_W-1:8] == '0));

    // R10: a waiting memory cycle keeps its request steady
    p_hold_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && $past(mem_stb) && !$past(mem_ack)) |->
        ($stable(mem_adr) && $stable(mem_sel) && $stable(mem_wdat) && $stable(mem_we)));
endmodule

// File: tb/tb_lane_split_bridge.sv
module tb_lane_split_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_cyc = 1'b0, up_stb = 1'b0, up_we = 1'b0, up_sext = 1'b0;
    logic [20:0] up_adr = '0;
    logic [3:0]  up_sel = '0;
    logic [31:0] up_wdat = '0;
    logic [31:0] up_rdat;
    logic        up_ack;
    logic        mem_cyc, mem_stb, mem_we;
    logic [18:0] mem_adr;
    logic [3:0]  mem_sel;
    logic [31:0] mem_wdat;
    logic [31:0] mem_rdat = '0;
    logic        mem_ack = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    lane_split_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .up_cyc(up_cyc), .up_stb(up_stb), .up_we(up_we), .up_adr(up_adr),
        .up_sel(up_sel), .up_sext(up_sext), .up_wdat(up_wdat),
        .up_rdat(up_rdat), .up_ack(up_ack),
        .mem_cyc(mem_cyc), .mem_stb(mem_stb), .mem_we(mem_we), .mem_adr(mem_adr),
        .mem_sel(mem_sel), .mem_wdat(mem_wdat), .mem_rdat(mem_rdat), .mem_ack(mem_ack)
    );

    // memory model: 64 words with random wait states
    logic [31:0] mem [64];
    logic [7:0]  refm [256];
    int          wait_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_stb) begin
            if (wait_cnt != 0) begin
                wait_cnt <= wait_cnt - 1;
            end else begin
                mem_ack  <= 1'b1;
                mem_rdat <= mem[mem_adr[5:0]];
                for (int l = 0; l < 4; l++)
                    if (mem_we && mem_sel[l]) mem[mem_adr[5:0]][8*l +: 8] <= mem_wdat[8*l +: 8];
                wait_cnt <= int'($urandom % 3);
            end
        end
    end

    // log of acknowledged memory cycles of the current access
    int          mon_n = 0;
    logic [18:0] lg_adr [2];
    logic [3:0]  lg_sel [2];
    always @(posedge clk) begin
        if (mem_stb && mem_ack) begin
            if (mon_n < 2) begin
                lg_adr[mon_n] = mem_adr;
                lg_sel[mon_n] = mem_sel;
            end
            mon_n = mon_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] sel_of(input int sz);
        return (sz == 1) ? 4'b0001 : (sz == 2) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic [31:0] exp_load(input logic [7:0] a, input int sz, input bit sx);
        logic [31:0] v = '0;
        for (int k = 0; k < sz; k++) v[8*k +: 8] = refm[8'(a + 8'(k))];
        if (sx && sz == 1) v[31:8]  = {24{v[7]}};
        if (sx && sz == 2) v[31:16] = {16{v[15]}};
        return v;
    endfunction

    task automatic access(input bit we, input logic [7:0] a, input int sz, input bit sx,
                          input logic [31:0] wd, input bit check_data);
        logic [7:0]  m8;
        int          exp_n;
        bit          gap = 0;
        int          guard = 0;
        logic [31:0] got;
        logic [31:0] ev;
        m8    = {4'b0000, sel_of(sz)} << a[1:0];
        exp_n = (int'(a[1:0]) + sz > 4) ? 2 : 1;
        @(negedge clk);
        mon_n   = 0;
        up_cyc  = 1'b1; up_stb = 1'b1; up_we = we; up_adr = {13'd0, a};
        up_sel  = sel_of(sz); up_sext = sx; up_wdat = wd;
        @(posedge clk); #1;
        // R10: scramble inputs while the access is in flight
        up_adr  = 21'($urandom); up_sel = 4'($urandom); up_wdat = $urandom;
        up_we   = 1'($urandom); up_sext = 1'($urandom);
        while (!up_ack && guard < 100) begin
            if (!mem_cyc) gap = 1;
            @(posedge clk); #1;
            guard++;
        end
        got = up_rdat;
        check(up_ack, "R6 ack arrives", {31'd0, up_ack}, 32'd1);
        check(mon_n == exp_n, (exp_n == 2) ? "R4 split cycle count" : "R5 single cycle count",
              mon_n, exp_n);
        check(!gap, "R4 cyc held across access", {31'd0, gap}, 32'd0);
        check(lg_adr[0] == 19'(a >> 2) && lg_sel[0] == m8[3:0], "R3 first cycle address/lanes",
              {9'd0, lg_sel[0], lg_adr[0]}, {9'd0, m8[3:0], 19'(a >> 2)});
        if (exp_n == 2 && mon_n == 2)
            check(lg_adr[1] == 19'(a >> 2) + 19'd1 && lg_sel[1] == m8[7:4], "R4 second cycle address/lanes",
                  {9'd0, lg_sel[1], lg_adr[1]}, {9'd0, m8[7:4], 19'(a >> 2) + 19'd1});
        if (we) begin
            for (int k = 0; k < sz; k++) refm[8'(a + 8'(k))] = wd[8*k +: 8];
        end else if (check_data) begin
            ev = exp_load(a, sz, sx);
            check(got == ev, (sz < 4) ? "R9 extended load" : "R8 load data", got, ev);
        end
        up_cyc = 1'b0; up_stb = 1'b0;
        @(posedge clk); #1;
        check(!up_ack, "R6 single ack pulse", {31'd0, up_ack}, 32'd0);
    endtask

    task automatic load_chk(input logic [7:0] a, input int sz, input bit sx,
                            input logic [31:0] exp, input string req);
        logic [31:0] ev;
        ev = exp_load(a, sz, sx);
        check(ev == exp, req, ev, exp);
        access(1'b0, a, sz, sx, 32'h0, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 64; i++) begin
            mem[i] = $urandom;
            for (int k = 0; k < 4; k++) refm[i*4 + k] = mem[i][8*k +: 8];
        end
        repeat (3) @(posedge clk);
        #1;
        check(!mem_stb && !mem_cyc && !up_ack, "R1 idle in reset",
              {29'd0, mem_stb, mem_cyc, up_ack}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        check(!mem_stb && !mem_cyc && !up_ack, "R1 idle after reset",
              {29'd0, mem_stb, mem_cyc, up_ack}, 32'd0);

        // R8 cross-word load check case
        access(1'b1, 8'h00, 4, 0, 32'h92837400, 0);
        access(1'b1, 8'h04, 4, 0, 32'hBECD0001, 0);
        load_chk(8'h03, 4, 0, 32'hCD000192, "R8 reference pattern model");

        // R7 byte stores with garbage above the byte, R2 little-endian
        access(1'b1, 8'h10, 4, 0, 32'h00000000, 0);
        access(1'b1, 8'h10, 1, 0, 32'hAABBCC34, 0);
        access(1'b1, 8'h11, 1, 0, 32'h9ABA9E56, 0);
        access(1'b1, 8'h12, 2, 0, 32'h77669A78, 0);
        load_chk(8'h10, 4, 0, 32'h9A785634, "R7 upper write bytes ignored");
        load_chk(8'h13, 1, 1, 32'hFFFFFF9A, "R9 byte sign fill");
        load_chk(8'h13, 1, 0, 32'h0000009A, "R9 byte zero fill");
        load_chk(8'h12, 1, 1, 32'h00000078, "R9 byte positive sign");

        // R4 2-byte crossing stores and loads
        access(1'b1, 8'h23, 2, 0, 32'h1234C32B, 0);
        load_chk(8'h23, 2, 1, 32'hFFFFC32B, "R9 half sign fill across words");
        load_chk(8'h23, 2, 0, 32'h0000C32B, "R9 half zero fill across words");
        // R4 wrap at top of modelled range: words 63 and 0
        access(1'b1, 8'hFE, 4, 0, 32'h44AFBECD, 0);
        load_chk(8'hFE, 4, 1, 32'h44AFBECD, "R8 full load ignores sign flag");

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            int sz;
            sz = (i % 3 == 0) ? 1 : (i % 3 == 1) ? 2 : 4;
            access(1'($urandom), 8'($urandom), sz, 1'($urandom), $urandom, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule